// File: doc/BRIEF.md
# Serial Port with Write-One Clear/Set Status

An asynchronous serial port controlled through a byte-wide register bus. Software programs a 16-bit rate divisor, a control register that sets word format and the line routing mode, and separate receive and transmit command registers. Bytes written to the shared buffer offset are sent as frames. Received frames land in a one-byte receive buffer at the same offset.

The line status and handshake status registers are sticky. Each one has two addresses. Writing ones at the first address clears the matching flags, and writing ones at the second address forces them. A single interrupt output combines the enabled receive and transmit conditions. DMA-routing and pause bits in the command registers are stored and read back, but they have no effect.

Top module: `ser_port`

## Requirements
- R1: One oversampling tick occurs every (divisor+1) clocks, and one bit lasts 16 ticks. The divisor high byte is at offset 0x10 and the low byte at 0x14. Both read back.
- R2: A byte written to offset 0x24 is sent on `txd` only while transmit command bit 7 (offset 0x20) is set. The frame is a low start bit, then data LSB first, then an optional parity bit, then high stop bits. Control register (0x18) bit 3 selects 8 data bits (0 selects 7). Bit 2 enables parity, bit 1 selects odd parity (0 selects even), and bit 0 selects two stop bits.
- R3: Line status bit 0x04 (holding empty) is low from a buffer write until the byte moves to the shifter. Bit 0x02 (shifter empty) is low while a frame is being sent. Reset value of line status is 0x06.
- R4: When receive command bit 7 (offset 0x1C) is set, a completed frame sets line status 0x80 (data ready). Reading offset 0x24 returns the byte (7-bit words read with bit 7 zero) and clears 0x80. With bit 7 clear, frames are ignored.
- R5: A low pulse on the receive line shorter than half a bit does not start a frame. The start bit is checked at the 8th tick.
- R6: A parity mismatch sets 0x10. A low stop bit sets 0x40 (framing). An all-zero frame with a low stop bit also sets 0x08 (break).
- R7: A frame that completes while 0x80 is set sets 0x20 (overrun), and that frame's byte is discarded.
- R8: Writing ones at offset 0x00 clears line status bits 7..3. Writing ones at offset 0x04 sets them. Bits 0x04 and 0x02 ignore both writes, and reads of 0x00 have no side effect.
- R9: Handshake status at offset 0x08 latches DSR (`dsr_in`) as 0x80 and CTS (`cts_in`) as 0x40. Writing ones at 0x08 clears them, and writing ones at 0x0C sets them.
- R10: `dtr_out` follows control bit 5 and `rts_out` follows control bit 4.
- R11: With control bit 6 (loopback) set, the transmitter output feeds the receiver internally and `txd` stays high.
- R12: With control bit 7 (auto-echo) set, `txd` follows `rxd` after a two-clock synchroniser, and transmitter output is not driven onto the line.
- R13: Transmit command bit 1 forces the line low (break) for as long as it is set.
- R14: `irq` is high when any of these holds: receive command bit 5 and data ready; receive command bit 4 and any of 0x40/0x20/0x10/0x08; transmit command bit 5 and holding empty; transmit command bit 4 and shifter empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dsr_in | input | 1 | DSR handshake input |
| cts_in | input | 1 | CTS handshake input |
| dtr_out | output | 1 | DTR handshake output |
| rts_out | output | 1 | RTS handshake output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are break detection and the error flags, because a well-behaved transmitter never produces them. Break is reached by holding the forced-low line in loopback for longer than a frame. Parity, framing and overrun errors come from frames the bench shapes itself on `rxd`, with a deliberately wrong parity bit, a low stop bit, or two frames sent without a read between them.

Each word format is covered by a full sweep of the 16 control-register combinations in loopback. Separate captures of `txd` check the bit-by-bit frame layout against frames the bench computes itself.

// File: rtl/ser_port.sv
`timescale 1ns/1ps
module ser_port #(
  parameter int          ADDR_W  = 6,
  parameter logic [15:0] RST_DIV = 16'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              rxd,
  output logic              txd,
  input  logic              dsr_in,
  input  logic              cts_in,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LCLR = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LSET = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_HCLR = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_HSET = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_DIVH = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_DIVL = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_RCMD = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_TCMD = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'('h24);
  localparam logic [3:0]        MID_TICK = 4'd7;
  localparam logic [3:0]        END_TICK = 4'd15;

  logic [15:0] div_q;
  logic [7:0]  ctl_q, rcmd_q, tcmd_q, rbr_q, thr_q;
  logic [7:3]  lsr_q;
  logic [1:0]  hsr_q;
  logic        thr_full;

  wire wr_lclr = bus_wr && bus_addr == A_LCLR;
  wire wr_lset = bus_wr && bus_addr == A_LSET;
  wire wr_hclr = bus_wr && bus_addr == A_HCLR;
  wire wr_hset = bus_wr && bus_addr == A_HSET;
  wire wr_buf  = bus_wr && bus_addr == A_BUF;
  wire rd_buf  = bus_rd && bus_addr == A_BUF;

  wire d8   = ctl_q[3];
  wire pen  = ctl_q[2];
  wire odd  = ctl_q[1];
  wire two  = ctl_q[0];
  wire lb   = ctl_q[6];
  wire echo = ctl_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= RST_DIV;
      ctl_q  <= '0;
      rcmd_q <= '0;
      tcmd_q <= '0;
      thr_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DIVH: div_q[15:8] <= bus_wdata;
        A_DIVL: div_q[7:0]  <= bus_wdata;
        A_CTL:  ctl_q       <= bus_wdata;
        A_RCMD: rcmd_q      <= bus_wdata;
        A_TCMD: tcmd_q      <= bus_wdata;
        A_BUF:  thr_q       <= bus_wdata;
        default: ;
      endcase
    end
  end

  logic [15:0] tk_cnt;
  wire tick = tk_cnt >= div_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tk_cnt <= '0;
    else if (tick) tk_cnt <= '0;
    else           tk_cnt <= tk_cnt + 16'd1;
  end

  logic rx_s1, rx_s2, rx_prev;
  logic [1:0] hs_s1, hs_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      hs_s1 <= '0;
      hs_s2 <= '0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      hs_s1 <= {dsr_in, cts_in};
      hs_s2 <= hs_s1;
    end
  end

  logic        tx_busy;
  logic [11:0] tx_sh, tx_fr;
  logic [3:0]  tx_left, tx_tc;
  wire  [7:0]  tx_dat = d8 ? thr_q : {1'b0, thr_q[6:0]};
  wire         tx_par = odd ^ (^tx_dat);
  wire  [3:0]  fr_len = 4'd1 + (d8 ? 4'd8 : 4'd7) + {3'd0, pen} + (two ? 4'd2 : 4'd1);
  wire         tx_load = tcmd_q[7] && thr_full && !tx_busy;

  always_comb begin
    tx_fr    = 12'hFFF;
    tx_fr[0] = 1'b0;
    if (d8) tx_fr[8:1] = thr_q;
    else    tx_fr[7:1] = thr_q[6:0];
    if (pen) begin
      if (d8) tx_fr[9] = tx_par;
      else    tx_fr[8] = tx_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_tc   <= '0;
    end else if (tx_load) begin
      tx_busy <= 1'b1;
      tx_sh   <= tx_fr;
      tx_left <= fr_len;
      tx_tc   <= '0;
    end else if (tx_busy && tick) begin
      tx_tc <= tx_tc + 4'd1;
      if (tx_tc == END_TICK) begin
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       thr_full <= 1'b0;
    else if (wr_buf)  thr_full <= 1'b1;
    else if (tx_load) thr_full <= 1'b0;
  end

  wire tx_int = tcmd_q[1] ? 1'b0 : (tx_busy ? tx_sh[0] : 1'b1);
  assign txd = lb ? 1'b1 : (echo ? rx_s2 : tx_int);

  wire rx_in = lb ? tx_int : rx_s2;
  logic        rx_act;
  logic [3:0]  rx_tc, rx_idx;
  logic [11:0] rx_fr;
  wire  [3:0]  rx_stop = (d8 ? 4'd9 : 4'd8) + {3'd0, pen};
  wire         rx_samp = rx_act && tick && rx_tc == MID_TICK;
  wire         rx_fin  = rx_samp && rx_idx == rx_stop;
  wire  [7:0]  rx_byte = d8 ? rx_fr[8:1] : {1'b0, rx_fr[7:1]};
  wire         rx_pbit = d8 ? rx_fr[9] : rx_fr[8];

  wire dr_ev = rx_fin && !lsr_q[7];
  wire oe_ev = rx_fin && lsr_q[7];
  wire fe_ev = rx_fin && !rx_in;
  wire pe_ev = rx_fin && pen && (rx_pbit != (odd ^ (^rx_byte)));
  wire bi_ev = fe_ev && rx_byte == 8'd0 && !(pen && rx_pbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      rx_act  <= 1'b0;
      rx_tc   <= '0;
      rx_idx  <= '0;
      rx_fr   <= '0;
    end else begin
      rx_prev <= rx_in;
      if (!rcmd_q[7]) begin
        rx_act <= 1'b0;
      end else if (!rx_act) begin
        if (rx_prev && !rx_in) begin
          rx_act <= 1'b1;
          rx_tc  <= '0;
          rx_idx <= '0;
        end
      end else if (tick) begin
        rx_tc <= rx_tc + 4'd1;
        if (rx_tc == MID_TICK) begin
          if ((rx_idx == 4'd0 && rx_in) || rx_fin) begin
            rx_act <= 1'b0;
          end else begin
            rx_fr[rx_idx] <= rx_in;
            rx_idx        <= rx_idx + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rbr_q <= '0;
    else if (dr_ev) rbr_q <= rx_byte;
  end

  wire [7:3] lsr_hw  = {dr_ev, fe_ev, oe_ev, pe_ev, bi_ev};
  wire [7:3] lsr_clr = (wr_lclr ? bus_wdata[7:3] : 5'd0) | {rd_buf, 4'd0};
  wire [7:3] lsr_set = wr_lset ? bus_wdata[7:3] : 5'd0;
  wire [1:0] hsr_clr = wr_hclr ? bus_wdata[7:6] : 2'd0;
  wire [1:0] hsr_set = wr_hset ? bus_wdata[7:6] : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsr_q <= '0;
      hsr_q <= '0;
    end else begin
      lsr_q <= (lsr_q & ~lsr_clr) | lsr_set | lsr_hw;
      hsr_q <= (hsr_q & ~hsr_clr) | hsr_set | hs_s2;
    end
  end

  wire [7:0] lsr_rd = {lsr_q, !thr_full, !tx_busy, 1'b0};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LCLR: bus_rdata = lsr_rd;
      A_HCLR: bus_rdata = {hsr_q, 6'd0};
      A_DIVH: bus_rdata = div_q[15:8];
      A_DIVL: bus_rdata = div_q[7:0];
      A_CTL:  bus_rdata = ctl_q;
      A_RCMD: bus_rdata = rcmd_q;
      A_TCMD: bus_rdata = tcmd_q;
      A_BUF:  bus_rdata = rbr_q;
      default: ;
    endcase
  end

  assign dtr_out = ctl_q[5];
  assign rts_out = ctl_q[4];
  assign irq = (rcmd_q[5] && lsr_q[7]) || (rcmd_q[4] && |lsr_q[6:3]) ||
               (tcmd_q[5] && !thr_full) || (tcmd_q[4] && !tx_busy);

  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != 16'd0 && !(bus_wr && (bus_addr == A_DIVH || bus_addr == A_DIVL))) |=> !tick);
  a_r3_buffer_taken: assert property (@(posedge clk) disable iff (!rst_n)
    wr_buf |=> !lsr_rd[2]);
  a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !rx_fin && !(wr_lset && bus_wdata[7])) |=> !lsr_q[7]);
  a_r7_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fin && lsr_q[7]) |=> (lsr_q[5] && $stable(rbr_q)));
  a_r8_set_forces_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lset && bus_wdata[6]) |=> lsr_q[6]);
endmodule

// File: tb/ser_port_tb.sv
`timescale 1ns/1ps
module ser_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata, v;
  logic bwr = 1'b0, brd = 1'b0, rxd = 1'b1, dsr = 1'b0, cts = 1'b0;
  logic txd, dtr, rts, irq;
  int checks = 0, errors = 0, bitc = 32;
  logic mon_lb = 1'b0, lb_bad = 1'b0, done = 1'b0;

  ser_port dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(bwr), .bus_rd(brd), .bus_rdata(rdata), .rxd(rxd), .txd(txd),
    .dsr_in(dsr), .cts_in(cts), .dtr_out(dtr), .rts_out(rts), .irq(irq));

  always #2.5 clk = ~clk;
  always @(negedge clk) if (mon_lb && txd == 1'b0) lb_bad = 1'b1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; bwr = 1'b1;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; brd = 1'b1; #1 d = rdata;
    @(negedge clk); brd = 1'b0;
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] expf(logic [7:0] b, logic [7:0] c, output int n);
    logic [11:0] f = 12'hFFF;
    int nd = c[3] ? 8 : 7;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[1+i] = b[i];
    if (c[2]) f[1+nd] = c[1] ^ (^(b & (c[3] ? 8'hFF : 8'h7F)));
    n = 1 + nd + int'(c[2]) + (c[0] ? 2 : 1);
    return f;
  endfunction

  task automatic send(logic [7:0] b, logic [7:0] c, bit badpar, bit stopv);
    int n;
    logic [11:0] f = expf(b, c, n);
    if (c[2]) f[(c[3] ? 9 : 8)] ^= badpar;
    f[n - (c[0] ? 2 : 1)] = stopv;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = f[i]; clks(bitc - 1);
    end
    @(negedge clk); rxd = 1'b1; clks(bitc);
  endtask

  task automatic capture(output logic [11:0] f, input int n);
    f = '1;
    while (txd !== 1'b0) @(negedge clk);
    clks(bitc / 2);
    f[0] = txd;
    for (int i = 1; i < n; i++) begin clks(bitc); f[i] = txd; end
  endtask

  task automatic wait_dr(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      rd(6'h00, s);
      if (s[7]) begin ok = 1'b1; return; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] fr, ef;
    int n, run;
    bit ok;
    logic [7:0] fmts [8] = '{8'h08, 8'h00, 8'h0C, 8'h0E, 8'h05, 8'h0F, 8'h09, 8'h06};
    logic [7:0] pats [4] = '{8'h3C, 8'hC5, 8'h7F, 8'h81};
    clks(3); rst_n = 1'b1; clks(2);

    rd(6'h00, v); chk("R3 reset status", v, 8'h06);
    chk("R14 reset irq", irq, 0);
    chk("R2 reset txd", txd, 1);
    rd(6'h14, v); chk("R1 reset divisor", v, 0);
    wr(6'h10, 8'h00); wr(6'h14, 8'h01);
    rd(6'h14, v); chk("R1 divisor low", v, 8'h01);
    wr(6'h10, 8'hA5); rd(6'h10, v); chk("R1 divisor high", v, 8'hA5);
    wr(6'h10, 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr(6'h04, 8'(1 << i)); rd(6'h00, v); rd(6'h00, v);
      chk("R8 set bit", v, 8'h06 | (8'(1 << i) & 8'hF8));
      wr(6'h00, 8'hFF); rd(6'h00, v); chk("R8 clear bit", v, 8'h06);
    end
    wr(6'h04, 8'hF8); wr(6'h00, 8'h50); rd(6'h00, v); chk("R8 partial clear", v, 8'hAE);
    wr(6'h00, 8'hFF);

    @(negedge clk); dsr = 1'b1; clks(5); dsr = 1'b0; clks(3);
    rd(6'h08, v); chk("R9 dsr latched", v, 8'h80);
    wr(6'h08, 8'hFF); rd(6'h08, v); chk("R9 clear", v, 8'h00);
    @(negedge clk); cts = 1'b1; clks(5); cts = 1'b0; clks(3);
    rd(6'h08, v); chk("R9 cts latched", v, 8'h40);
    wr(6'h08, 8'hFF); wr(6'h0C, 8'h80); rd(6'h08, v); chk("R9 set", v, 8'h80);
    wr(6'h08, 8'hFF);

    wr(6'h18, 8'h30); chk("R10 dtr", dtr, 1); chk("R10 rts", rts, 1);
    wr(6'h18, 8'h10); chk("R10 dtr off", dtr, 0); chk("R10 rts on", rts, 1);

    wr(6'h18, 8'h08); wr(6'h24, 8'h55); clks(100);
    rd(6'h00, v); chk("R3 held while tx disabled", v, 8'h02);
    chk("R2 disabled line idle", txd, 1);
    wr(6'h20, 8'h80);
    ef = expf(8'h55, 8'h08, n); capture(fr, n);
    chk("R2 frame 55", fr & ((12'h1 << n) - 1), ef & ((12'h1 << n) - 1));
    clks(bitc * 2);
    foreach (fmts[k]) for (int j = 0; j < 2; j++) begin
      logic [7:0] b = j ? 8'hA3 : 8'h5C;
      wr(6'h18, fmts[k]); wr(6'h24, b);
      ef = expf(b, fmts[k], n); capture(fr, n);
      chk($sformatf("R2 frame fmt %0h", fmts[k]), fr & ((12'h1 << n) - 1), ef & ((12'h1 << n) - 1));
      clks(bitc * 2);
    end
    wr(6'h18, 8'h08); wr(6'h24, 8'h12); wr(6'h24, 8'h34);
    rd(6'h00, v); chk("R3 both busy", v, 8'h00);
    clks(bitc * 22); rd(6'h00, v); chk("R3 both empty", v, 8'h06);

    wr(6'h14, 8'h03); wr(6'h24, 8'h0F);
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    run = 0;
    while (txd === 1'b0) begin run++; @(negedge clk); end
    chk("R1 four-bit low run at divisor 3", run, 4 * 64);
    clks(200); wr(6'h14, 8'h01);

    wr(6'h20, 8'h82); clks(2); chk("R13 break low", txd, 0);
    wr(6'h20, 8'h80); clks(2); chk("R13 break released", txd, 1);

    wr(6'h1C, 8'h80); wr(6'h00, 8'hFF); mon_lb = 1'b1;
    for (int c = 0; c < 16; c++) begin
      wr(6'h18, 8'h40 | 8'(c));
      foreach (pats[p]) begin
        wr(6'h24, pats[p]); wait_dr(ok);
        chk("R11 loopback ready", ok, 1);
        rd(6'h24, v);
        chk($sformatf("R11 loopback data cfg %0h", c), v, pats[p] & (c[3] ? 8'hFF : 8'h7F));
        rd(6'h00, v); chk("R11 loopback clean status", v & 8'hF8, 0);
      end
    end
    mon_lb = 1'b0; chk("R11 txd high in loopback", lb_bad, 0);

    wr(6'h18, 8'h48); wr(6'h20, 8'h82); clks(500); wr(6'h20, 8'h80); clks(50);
    rd(6'h00, v); chk("R6 break flags", v, 8'hCE);
    rd(6'h24, v); chk("R6 break byte", v, 8'h00);
    wr(6'h00, 8'hFF);

    wr(6'h18, 8'h0C);
    send(8'hA5, 8'h0C, 0, 1); rd(6'h00, v); chk("R4 ready", v, 8'h86);
    rd(6'h24, v); chk("R4 data", v, 8'hA5);
    rd(6'h00, v); chk("R4 read clears ready", v, 8'h06);
    send(8'h3C, 8'h0C, 1, 1); rd(6'h00, v); chk("R6 parity error", v, 8'h96);
    rd(6'h24, v); wr(6'h00, 8'hFF);
    send(8'h5A, 8'h0C, 0, 0); rd(6'h00, v); chk("R6 framing error", v, 8'hC6);
    rd(6'h24, v); wr(6'h00, 8'hFF);
    send(8'h11, 8'h0C, 0, 1); send(8'h22, 8'h0C, 0, 1);
    rd(6'h00, v); chk("R7 overrun flag", v, 8'hA6);
    rd(6'h24, v); chk("R7 first byte kept", v, 8'h11);
    wr(6'h00, 8'hFF);
    wr(6'h1C, 8'h00); send(8'h77, 8'h0C, 0, 1);
    rd(6'h00, v); chk("R4 receiver disabled", v, 8'h06);
    wr(6'h1C, 8'h80);
    @(negedge clk); rxd = 1'b0; clks(10); rxd = 1'b1; clks(600);
    rd(6'h00, v); chk("R5 glitch ignored", v, 8'h06);
    send(8'h42, 8'h0C, 0, 1); rd(6'h24, v); chk("R5 receive after glitch", v, 8'h42);

    wr(6'h20, 8'hA0); chk("R14 holding empty irq", irq, 1);
    wr(6'h20, 8'h90); chk("R14 shifter empty irq", irq, 1);
    wr(6'h20, 8'h80); chk("R14 tx irq off", irq, 0);
    wr(6'h1C, 8'hA0); chk("R14 no ready", irq, 0);
    wr(6'h04, 8'h80); chk("R14 ready irq", irq, 1);
    wr(6'h1C, 8'h90); chk("R14 ready not error", irq, 0);
    wr(6'h04, 8'h20); chk("R14 error irq", irq, 1);
    wr(6'h00, 8'hFF); chk("R14 cleared", irq, 0);

    wr(6'h1C, 8'h00); wr(6'h18, 8'h88); wr(6'h24, 8'h00);
    clks(4); chk("R12 echo high", txd, 1);
    @(negedge clk); rxd = 1'b0; clks(4); chk("R12 echo low", txd, 0);
    rxd = 1'b1; clks(4); chk("R12 echo high again", txd, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule